// File: doc/BRIEF.md
# Power Partition Gating Controller

This block keeps the power state and the output isolation clamp of up to `NUM_PART` switchable power partitions. Software reaches it through a plain register write/read port. A power change is requested with a command write. The write must carry a start flag and a partition index. The controller does not drive the partition to a given level: it inverts the current state of that partition. The new state takes effect after a fixed settling window, which stands in for the time a power switch needs to settle. Software then polls a status word until the bit for the partition reaches the value it expects.

Clamps are released by a separate write-one-to-release register. Two partitions, selected by `SWAP_A` and `SWAP_B`, have their release bits crossed with each other, so a write to bit `SWAP_A` releases partition `SWAP_B` and a write to bit `SWAP_B` releases partition `SWAP_A`. When a partition powers down, its clamp closes again by itself.

The command sequencer is a three-state machine:
- `ST_IDLE` waits for a command. The transition *accept* moves it to `ST_SETTLE` and latches the index.
- `ST_SETTLE` counts down the settling window. The transition *settled* moves it to `ST_COMMIT` once the count reaches zero.
- `ST_COMMIT` flips the latched partition for one cycle. The transition *done* returns it to `ST_IDLE`.

Top module: `pwr_part_ctrl`

## Requirements
- R1: After reset every partition is unpowered (`part_pwr_en` all 0) and clamped (`part_clamp` all 1), and a status read returns 0.
- R2: An accepted command inverts the power state of the indexed partition and of no other partition. A second command to the same partition undoes the first.
- R3: The write that is accepted is sampled at clock edge E. The power bit changes at edge E+`SETTLE_CYC`+1 and holds its old value before that edge.
- R4: A read with `reg_addr` = 0x38 returns the power state in `reg_rdata`, where bit n is 1 when partition n is powered.
- R5: A write to 0x30 with bit 8 (the start flag) at 0 changes no power state and no clamp.
- R6: A command that arrives while an earlier command is still settling or committing is dropped. This holds for any index, including the same partition.
- R7: Bits [7:0] of the command carry the index. An index of `NUM_PART` or more is dropped and does not make the sequencer busy.
- R8: A write to 0x34 clears `part_clamp[n]` at the next edge for each set bit n. Clear bits leave their clamps unchanged. Powering a partition on does not open its clamp.
- R9: In the release mask, bit `SWAP_A` (default 2) releases partition `SWAP_B` (default 3), and bit `SWAP_B` releases partition `SWAP_A`.
- R10: When a partition goes from powered to unpowered, its clamp is set at the same edge. This takes priority over a release that falls on that edge.
- R11: A read of any address other than 0x38 returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Write strobe, one cycle per write |
| reg_addr | input | 8 | Register byte address |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Read data for `reg_addr`, combinational |
| part_pwr_en | output | NUM_PART | Power enable for each partition |
| part_clamp | output | NUM_PART | Isolation clamp for each partition, 1 = clamped |

## Verification
The assertions check the following on every cycle:
- no more than one power bit changes at an edge;
- a power bit changes only on a commit pulse;
- a partition that powers down is clamped at that edge;
- the latched index stays fixed while the sequencer is busy;
- the commit state lasts exactly one cycle.

Only the bench scenarios can show the rest: the exact settling latency, the dropped commands (no start flag, busy, index out of range), the crossed release bits, and the status read. To do so, the bench runs a behavioural model alongside the block and compares the two on every cycle.

// File: rtl/pgc_pkg.sv
package pgc_pkg;
    localparam int REG_ADDR_W  = 8;
    localparam int IDX_FIELD_W = 8;
    localparam int START_BIT   = 8;

    localparam logic [REG_ADDR_W-1:0] OFS_TOGGLE = 8'h30;
    localparam logic [REG_ADDR_W-1:0] OFS_CLAMP  = 8'h34;
    localparam logic [REG_ADDR_W-1:0] OFS_STATUS = 8'h38;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_SETTLE = 2'd1,
        ST_COMMIT = 2'd2
    } seq_state_e;
endpackage

// File: rtl/pgc_decode.sv
module pgc_decode
    import pgc_pkg::*;
#(
    parameter int NUM_PART = 32,
    parameter int DATA_W   = 32,
    parameter int SWAP_A   = 2,
    parameter int SWAP_B   = 3
) (
    input  logic                   reg_wr,
    input  logic [REG_ADDR_W-1:0]  reg_addr,
    input  logic [DATA_W-1:0]      reg_wdata,
    input  logic [NUM_PART-1:0]    pwr_state,
    output logic                   tog_req,
    output logic [IDX_FIELD_W-1:0] tog_idx,
    output logic [NUM_PART-1:0]    rel_mask,
    output logic [DATA_W-1:0]      reg_rdata
);
    localparam logic [IDX_FIELD_W:0] PART_LIMIT = (IDX_FIELD_W+1)'(NUM_PART);

    logic clamp_wr;
    logic idx_ok;

    assign tog_idx  = reg_wdata[IDX_FIELD_W-1:0];
    assign idx_ok   = ({1'b0, tog_idx} < PART_LIMIT);
    assign tog_req  = reg_wr && (reg_addr == OFS_TOGGLE) && reg_wdata[START_BIT] && idx_ok;
    assign clamp_wr = reg_wr && (reg_addr == OFS_CLAMP);

    // release mask with the two crossed partitions
    for (genvar n = 0; n < NUM_PART; n++) begin : g_rel
        if (n == SWAP_A) begin : g_sa
            assign rel_mask[n] = clamp_wr && reg_wdata[SWAP_B];
        end else if (n == SWAP_B) begin : g_sb
            assign rel_mask[n] = clamp_wr && reg_wdata[SWAP_A];
        end else begin : g_pl
            assign rel_mask[n] = clamp_wr && reg_wdata[n];
        end
    end

    always_comb begin
        reg_rdata = '0;
        if (reg_addr == OFS_STATUS) begin
            reg_rdata[NUM_PART-1:0] = pwr_state;
        end
    end
endmodule

// File: rtl/pgc_seq.sv
module pgc_seq
    import pgc_pkg::*;
#(
    parameter int SETTLE_CYC = 4
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   tog_req,
    input  logic [IDX_FIELD_W-1:0] tog_idx,
    output logic                   flip,
    output logic [IDX_FIELD_W-1:0] flip_idx
);
    localparam int CNT_W = $clog2(SETTLE_CYC + 1);
    localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(SETTLE_CYC - 1);

    seq_state_e             state_q, state_d;
    logic [CNT_W-1:0]       cnt_q, cnt_d;
    logic [IDX_FIELD_W-1:0] idx_q, idx_d;

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        idx_d   = idx_q;
        unique case (state_q)
            ST_IDLE: begin
                if (tog_req) begin          // accept
                    state_d = ST_SETTLE;
                    cnt_d   = CNT_LOAD;
                    idx_d   = tog_idx;
                end
            end
            ST_SETTLE: begin
                if (cnt_q == '0) begin      // settled
                    state_d = ST_COMMIT;
                end else begin
                    cnt_d = cnt_q - CNT_W'(1);
                end
            end
            ST_COMMIT: begin
                state_d = ST_IDLE;          // done
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
            idx_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            idx_q   <= idx_d;
        end
    end

    always_comb begin
        flip     = (state_q == ST_COMMIT);
        flip_idx = idx_q;
    end

    AST_IDX_HELD_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_IDLE) |=> $stable(idx_q)); // R6
    AST_COMMIT_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_COMMIT) |=> (state_q == ST_IDLE)); // R3
endmodule

// File: rtl/pgc_bank.sv
module pgc_bank
    import pgc_pkg::*;
#(
    parameter int NUM_PART = 32
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   flip,
    input  logic [IDX_FIELD_W-1:0] flip_idx,
    input  logic [NUM_PART-1:0]    rel_mask,
    output logic [NUM_PART-1:0]    pwr_en,
    output logic [NUM_PART-1:0]    clamp
);
    for (genvar n = 0; n < NUM_PART; n++) begin : g_part
        logic hit;
        logic pwr_q;
        logic clamp_q;

        assign hit = flip && (flip_idx == IDX_FIELD_W'(n));

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                pwr_q   <= 1'b0;
                clamp_q <= 1'b1;
            end else begin
                if (hit) begin
                    pwr_q <= ~pwr_q;
                end
                if (hit && pwr_q) begin
                    clamp_q <= 1'b1;
                end else if (rel_mask[n]) begin
                    clamp_q <= 1'b0;
                end
            end
        end

        assign pwr_en[n] = pwr_q;
        assign clamp[n]  = clamp_q;
    end

    AST_SINGLE_FLIP: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(pwr_en ^ $past(pwr_en)) <= 1); // R2
    AST_FLIP_NEEDS_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
        (pwr_en != $past(pwr_en)) |-> $past(flip)); // R5
    AST_OFF_RECLAMPS: assert property (@(posedge clk) disable iff (!rst_n)
        (($past(pwr_en) & ~pwr_en) != '0) |-> ((($past(pwr_en) & ~pwr_en) & ~clamp) == '0)); // R10
endmodule

// File: rtl/pwr_part_ctrl.sv
module pwr_part_ctrl
    import pgc_pkg::*;
#(
    parameter int NUM_PART   = 32,
    parameter int DATA_W     = 32,
    parameter int SETTLE_CYC = 4,
    parameter int SWAP_A     = 2,
    parameter int SWAP_B     = 3
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  reg_wr,
    input  logic [REG_ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0]     reg_wdata,
    output logic [DATA_W-1:0]     reg_rdata,
    output logic [NUM_PART-1:0]   part_pwr_en,
    output logic [NUM_PART-1:0]   part_clamp
);
    logic                   tog_req;
    logic [IDX_FIELD_W-1:0] tog_idx;
    logic [NUM_PART-1:0]    rel_mask;
    logic                   flip;
    logic [IDX_FIELD_W-1:0] flip_idx;

    pgc_decode #(
        .NUM_PART (NUM_PART),
        .DATA_W   (DATA_W),
        .SWAP_A   (SWAP_A),
        .SWAP_B   (SWAP_B)
    ) u_decode (
        .reg_wr    (reg_wr),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .pwr_state (part_pwr_en),
        .tog_req   (tog_req),
        .tog_idx   (tog_idx),
        .rel_mask  (rel_mask),
        .reg_rdata (reg_rdata)
    );

    pgc_seq #(
        .SETTLE_CYC (SETTLE_CYC)
    ) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .tog_req  (tog_req),
        .tog_idx  (tog_idx),
        .flip     (flip),
        .flip_idx (flip_idx)
    );

    pgc_bank #(
        .NUM_PART (NUM_PART)
    ) u_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .flip     (flip),
        .flip_idx (flip_idx),
        .rel_mask (rel_mask),
        .pwr_en   (part_pwr_en),
        .clamp    (part_clamp)
    );
endmodule

// File: tb/pwr_part_ctrl_bench.sv
module pwr_part_ctrl_bench;
    localparam int CLK_PERIOD = 10;
    localparam int NP  = 32;
    localparam int DW  = 32;
    localparam int SC  = 4;
    localparam int LAT = SC + 1;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          reg_wr = 1'b0;
    logic [7:0]    reg_addr = 8'h00;
    logic [DW-1:0] reg_wdata = '0;
    logic [DW-1:0] reg_rdata;
    logic [NP-1:0] part_pwr_en;
    logic [NP-1:0] part_clamp;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    logic [NP-1:0] m_pwr = '0;
    logic [NP-1:0] m_clamp = '1;
    int m_cnt = 0;
    int m_idx = 0;

    pwr_part_ctrl #(.NUM_PART(NP), .DATA_W(DW), .SETTLE_CYC(SC), .SWAP_A(2), .SWAP_B(3)) u_pwr_part_ctrl (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .part_pwr_en(part_pwr_en), .part_clamp(part_clamp)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(string req, logic [DW-1:0] act, logic [DW-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // behavioural reference model
    always @(posedge clk) begin
        logic [NP-1:0] rel;
        logic [NP-1:0] nclamp;
        if (!rst_n) begin
            m_pwr = '0; m_clamp = '1; m_cnt = 0; m_idx = 0;
        end else begin
            rel = '0;
            if (reg_wr && reg_addr == 8'h34) begin
                rel = reg_wdata[NP-1:0];
                rel[2] = reg_wdata[3];
                rel[3] = reg_wdata[2];
            end
            nclamp = m_clamp & ~rel;
            if (m_cnt != 0) begin
                m_cnt = m_cnt - 1;
                if (m_cnt == 0) begin
                    m_pwr[m_idx] = ~m_pwr[m_idx];
                    if (!m_pwr[m_idx]) nclamp[m_idx] = 1'b1;
                end
            end else if (reg_wr && reg_addr == 8'h30 && reg_wdata[8] && reg_wdata[7:0] < NP) begin
                m_cnt = LAT;
                m_idx = int'(reg_wdata[7:0]);
            end
            m_clamp = nclamp;
        end
    end

    // per-cycle comparison, a quarter period after the edge
    always @(posedge clk) begin
        #(CLK_PERIOD/4);
        if (rst_n && !done) begin
            check("R2,R3 model pwr", DW'(part_pwr_en), DW'(m_pwr));
            check("R8,R10 model clamp", DW'(part_clamp), DW'(m_clamp));
            check("R4,R11 model rdata", reg_rdata, (reg_addr == 8'h38) ? DW'(m_pwr) : '0);
        end
    end

    task automatic wr(logic [7:0] a, logic [DW-1:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0; reg_addr = 8'h00; reg_wdata = '0;
    endtask

    task automatic wait_n(int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic rd(logic [7:0] a, output logic [DW-1:0] d);
        @(negedge clk);
        reg_addr = a;
        #1;
        d = reg_rdata;
        @(negedge clk);
        reg_addr = 8'h00;
    endtask

    task automatic finish_run();
        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        #(CLK_PERIOD * 20000);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired actual=hung expected=finished");
        finish_run();
    end

    initial begin
        logic [DW-1:0] rv;
        logic [NP-1:0] snap_p;
        logic [NP-1:0] snap_c;
        wait_n(3);
        rst_n = 1'b1;
        wait_n(1);
        // R1 reset state
        check("R1 pwr after reset", DW'(part_pwr_en), '0);
        check("R1 clamp after reset", DW'(part_clamp), '1);
        rd(8'h38, rv);
        check("R1 status after reset", rv, '0);

        // R2 / R3 power on partition 5 with exact latency
        wr(8'h30, 32'h105);
        wait_n(LAT - 1);
        check("R3 bit5 before settle", DW'(part_pwr_en[5]), 0);
        wait_n(1);
        check("R3 bit5 after settle", DW'(part_pwr_en[5]), 1);
        check("R2 only bit5 powered", DW'(part_pwr_en), 32'h0000_0020);
        check("R8 power-on keeps clamp", DW'(part_clamp[5]), 1);
        rd(8'h38, rv);
        check("R4 status read", rv, 32'h0000_0020);

        // R5 start flag clear
        snap_p = part_pwr_en; snap_c = part_clamp;
        wr(8'h30, 32'h006);
        wait_n(LAT + 3);
        check("R5 no start flag pwr", DW'(part_pwr_en), DW'(snap_p));
        check("R5 no start flag clamp", DW'(part_clamp), DW'(snap_c));

        // R6 command while busy dropped
        wr(8'h30, 32'h107);
        wr(8'h30, 32'h109);
        wr(8'h30, 32'h107);
        wait_n(LAT + 4);
        check("R6 first command applied", DW'(part_pwr_en[7]), 1);
        check("R6 busy command dropped", DW'(part_pwr_en[9]), 0);

        // R7 out-of-range index dropped, not busy afterwards
        snap_p = part_pwr_en;
        wr(8'h30, 32'h128);
        wait_n(LAT + 3);
        check("R7 index 40 ignored", DW'(part_pwr_en), DW'(snap_p));
        wr(8'h30, 32'h10A);
        wr(8'h30, 32'h120);
        wait_n(LAT + 2);
        check("R7 sequencer free after bad index", DW'(part_pwr_en[10]), 1);
        check("R7 index 32 ignored", DW'(part_pwr_en), DW'(snap_p | 32'h0000_0400));

        // R8 clamp release, R9 swapped bits
        wr(8'h34, 32'h0000_0020);
        check("R8 release bit5", DW'(part_clamp), 32'hFFFF_FFDF);
        wr(8'h34, 32'h0000_0004);
        check("R9 bit2 releases partition 3", DW'(part_clamp[3]), 0);
        check("R9 partition 2 still clamped", DW'(part_clamp[2]), 1);
        wr(8'h34, 32'h0000_0008);
        check("R9 bit3 releases partition 2", DW'(part_clamp[2]), 0);

        // R10 power off re-clamps, R2 second toggle undoes
        wr(8'h30, 32'h105);
        wait_n(LAT);
        check("R2 second toggle powers off", DW'(part_pwr_en[5]), 0);
        check("R10 off sets clamp", DW'(part_clamp[5]), 1);

        // R10 priority: release on the same edge as power-off
        wr(8'h34, 32'h0000_0020);
        check("R8 release bit5 again", DW'(part_clamp[5]), 0);
        wr(8'h30, 32'h105);
        wait_n(LAT);
        check("R2 bit5 on again", DW'(part_pwr_en[5]), 1);
        wr(8'h30, 32'h105);
        wait_n(LAT - 2);
        wr(8'h34, 32'h0000_0020);
        check("R10 off beats release", DW'(part_clamp[5]), 1);
        check("R10 bit5 off", DW'(part_pwr_en[5]), 0);

        // R11 other addresses read 0
        rd(8'h30, rv);
        check("R11 read toggle addr", rv, '0);
        rd(8'h34, rv);
        check("R11 read clamp addr", rv, '0);

        wait_n(2);
        finish_run();
    end
endmodule